// File: doc/BRIEF.md
# Fractional-N Channel Word Decoder

This block converts a 16-bit channel word, whose least significant bit is worth 50 kHz, into the per-cycle feedback divide value for a fractional-N synthesizer. The synthesizer runs from a 26 MHz reference. In both bands the oscillator runs at the word times 100 kHz. In high band the word equals the LO frequency and the oscillator runs at twice the LO. In low band the word is twice the LO and the oscillator runs at four times the LO. The feedback ratio is therefore always word/260. The block splits this ratio into an integer part and a numerator modulo 260. A third-order cascaded accumulator modulator then dithers the integer part on every reference cycle.

A load strobe presents a new word and band. The block checks the word against an allowed window that is set per band. An accepted word restarts the modulator from a cleared state. A rejected word raises an out-of-range flag and freezes the divide output. The synth enable stops the modulator and freezes the output. Transmit and receive paths each use their own instance.

Top module: `fracnChanDecoder`

## Requirements
- R1: While reset is asserted, `divOut` is 0, `divValid` is 0 and `outOfRange` is 0.
- R2: For an accepted word, the integer part is floor(word/260) and the numerator is word mod 260. When the numerator is 0, every emitted value equals the integer part.
- R3: The modulator has three accumulators, each of modulus 260. Stage 1 adds the numerator, and each later stage adds the new residue of the stage before it. A stage carries (1) when its sum is 260 or more, and 260 is then subtracted from the sum. Each step emits integer + c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' means the value from the previous step.
- R4: Every emitted value lies between the integer part − 3 and the integer part + 4.
- R5: Let S be the sum of the first 260 values after a load. Then |260·(S − 260·integer) − 260·numerator| ≤ 780.
- R6: The clock edge that samples `load` clears the accumulators and their delay registers. After that edge `divValid` is 0. The first value of the new word appears after the next edge, with `divValid` = 1.
- R7: A word is accepted when it lies within [HB_MIN_WORD, HB_MAX_WORD] with `bandSel` = 1 (high band), or within [LB_MIN_WORD, LB_MAX_WORD] with `bandSel` = 0 (low band). `outOfRange` updates on the load edge: 1 if the word is rejected, 0 if it is accepted.
- R8: After a rejected load, `divOut` holds its previous value and `divValid` stays 0 until an accepted load arrives.
- R9: While `enable` is 0, `divValid` is 0 after the next edge, `divOut` holds, and the modulator state is cleared. When `enable` returns to 1, the sequence restarts from its first value.
- R10: Until a word has been accepted, `divValid` stays 0 even when `enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Synthesizer enable |
| bandSel | input | 1 | 1 = high band, 0 = low band |
| load | input | 1 | Load strobe for chanWord and bandSel |
| chanWord | input | 16 | Channel word in 50 kHz steps |
| divOut | output | 9 | Instantaneous feedback divide value |
| divValid | output | 1 | divOut carries a fresh modulator value |
| outOfRange | output | 1 | Last loaded word was rejected |

## Verification
The bench keeps the high-band window at its default of 34000 to 44000. It narrows the low-band upper limit to 43000, so one word is accepted in high band but rejected in low band, which shows that the band input takes part in the range check. With a modulus of 260 the bench can compare every output over 300 cycles against an independent model of the three accumulators. It uses numerators of 0, 60, 130 and 200 and words at both window edges and one step beyond them.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  typedef struct packed {
    logic capture;
    logic clear;
    logic step;
  } ctlStrb_t;
endpackage

// File: rtl/chanDecode.sv
module chanDecode #(
  parameter int WORD_W      = 16,
  parameter int MOD         = 260,
  parameter int INT_W       = 8,
  parameter int FRAC_W      = 9,
  parameter int HB_MIN_WORD = 34000,
  parameter int HB_MAX_WORD = 44000,
  parameter int LB_MIN_WORD = 34000,
  parameter int LB_MAX_WORD = 44000
) (
  input  logic [WORD_W-1:0] chanWord,
  input  logic              bandSel,
  output logic [INT_W-1:0]  intPart,
  output logic [FRAC_W-1:0] fracPart,
  output logic              inRange
);
  localparam logic [WORD_W-1:0] MOD_W = WORD_W'(MOD);
  localparam logic [WORD_W-1:0] HB_LO = WORD_W'(HB_MIN_WORD);
  localparam logic [WORD_W-1:0] HB_HI = WORD_W'(HB_MAX_WORD);
  localparam logic [WORD_W-1:0] LB_LO = WORD_W'(LB_MIN_WORD);
  localparam logic [WORD_W-1:0] LB_HI = WORD_W'(LB_MAX_WORD);

  logic [WORD_W-1:0] lowLim, highLim;

  assign intPart  = INT_W'(chanWord / MOD_W);
  assign fracPart = FRAC_W'(chanWord % MOD_W);
  assign lowLim   = bandSel ? HB_LO : LB_LO;
  assign highLim  = bandSel ? HB_HI : LB_HI;
  assign inRange  = (chanWord >= lowLim) && (chanWord <= highLim);
endmodule

// File: rtl/fracnCtrl.sv
module fracnCtrl
  import fracn_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     load,
  input  logic     inRange,
  output ctlStrb_t strb,
  output logic     divValid,
  output logic     outOfRange
);
  logic haveWord, oorFlag, validReg;

  assign strb.capture = load & inRange;
  assign strb.clear   = (load & inRange) | ~enable;
  assign strb.step    = enable & haveWord & ~oorFlag & ~load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveWord <= 1'b0;
      oorFlag  <= 1'b0;
      validReg <= 1'b0;
    end else begin
      if (strb.capture) haveWord <= 1'b1;
      if (load)         oorFlag  <= ~inRange;
      validReg <= strb.step;
    end
  end

  assign divValid   = validReg;
  assign outOfRange = oorFlag;

  // R8
  oor_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outOfRange |-> !divValid);
  // R6
  load_drops_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    load |=> !divValid);
  // R9
  enable_drops_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !divValid);
endmodule

// File: rtl/mashCore.sv
module mashCore
  import fracn_pkg::*;
#(
  parameter int MOD    = 260,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 9,
  parameter int DIV_W  = INT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [INT_W-1:0]  intIn,
  input  logic [FRAC_W-1:0] fracIn,
  output logic [DIV_W-1:0]  divOut
);
  localparam int STAGES = 3;
  localparam logic [FRAC_W:0] MOD_S = (FRAC_W+1)'(MOD);

  logic [INT_W-1:0]  intReg;
  logic [FRAC_W-1:0] fracReg;
  logic [FRAC_W-1:0] acc    [STAGES];
  logic [FRAC_W-1:0] accNxt [STAGES];
  logic [FRAC_W-1:0] addend [STAGES];
  logic [STAGES-1:0] cy;
  logic              c2p, c3p, c3pp;
  logic [3:0]        corr;
  logic [DIV_W-1:0]  nextDiv;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [FRAC_W:0] sum;
    if (g == 0) begin : g_first
      assign addend[g] = fracReg;
    end else begin : g_chain
      assign addend[g] = accNxt[g-1];
    end
    assign sum       = {1'b0, acc[g]} + {1'b0, addend[g]};
    assign cy[g]     = (sum >= MOD_S);
    assign accNxt[g] = FRAC_W'(cy[g] ? sum - MOD_S : sum);
  end

  assign corr = 4'(cy[0]) + 4'(cy[1]) - 4'(c2p)
              + 4'(cy[2]) - 4'({c3p, 1'b0}) + 4'(c3pp);
  assign nextDiv = {1'b0, intReg} + {{(DIV_W-4){corr[3]}}, corr};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intReg  <= '0;
      fracReg <= '0;
      divOut  <= '0;
      c2p     <= 1'b0;
      c3p     <= 1'b0;
      c3pp    <= 1'b0;
      for (int i = 0; i < STAGES; i++) acc[i] <= '0;
    end else begin
      if (strb.capture) begin
        intReg  <= intIn;
        fracReg <= fracIn;
      end
      if (strb.clear) begin
        c2p  <= 1'b0;
        c3p  <= 1'b0;
        c3pp <= 1'b0;
        for (int i = 0; i < STAGES; i++) acc[i] <= '0;
      end else if (strb.step) begin
        divOut <= nextDiv;
        c2p    <= cy[1];
        c3p    <= cy[2];
        c3pp   <= c3p;
        for (int i = 0; i < STAGES; i++) acc[i] <= accNxt[i];
      end
    end
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> $stable(divOut));
  // R4
  corr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (divOut <= {1'b0, intReg} + DIV_W'(4)) &&
                  (divOut + DIV_W'(3) >= {1'b0, intReg}));
endmodule

// File: rtl/fracnChanDecoder.sv
module fracnChanDecoder
  import fracn_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int MOD         = 260,
  parameter int HB_MIN_WORD = 34000,
  parameter int HB_MAX_WORD = 44000,
  parameter int LB_MIN_WORD = 34000,
  parameter int LB_MAX_WORD = 44000,
  localparam int INT_W  = $clog2((2**WORD_W - 1) / MOD + 1),
  localparam int FRAC_W = $clog2(MOD),
  localparam int DIV_W  = INT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bandSel,
  input  logic              load,
  input  logic [WORD_W-1:0] chanWord,
  output logic [DIV_W-1:0]  divOut,
  output logic              divValid,
  output logic              outOfRange
);
  logic [INT_W-1:0]  intPart;
  logic [FRAC_W-1:0] fracPart;
  logic              inRange;
  ctlStrb_t          strb;

  chanDecode #(
    .WORD_W(WORD_W), .MOD(MOD), .INT_W(INT_W), .FRAC_W(FRAC_W),
    .HB_MIN_WORD(HB_MIN_WORD), .HB_MAX_WORD(HB_MAX_WORD),
    .LB_MIN_WORD(LB_MIN_WORD), .LB_MAX_WORD(LB_MAX_WORD)
  ) u_decode (
    .chanWord(chanWord), .bandSel(bandSel),
    .intPart(intPart), .fracPart(fracPart), .inRange(inRange)
  );

  fracnCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .load(load), .inRange(inRange),
    .strb(strb), .divValid(divValid), .outOfRange(outOfRange)
  );

  mashCore #(
    .MOD(MOD), .INT_W(INT_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W)
  ) u_mash (
    .clk(clk), .rstN(rstN), .strb(strb),
    .intIn(intPart), .fracIn(fracPart), .divOut(divOut)
  );
endmodule

// File: tb/test_fracnChanDecoder.sv
module test_fracnChanDecoder;
  typedef struct packed {
    logic [15:0] word;
    logic        band;
    logic        expOor;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'd34000, 1'b1, 1'b0},
    '{16'd44000, 1'b1, 1'b0},
    '{16'd35100, 1'b1, 1'b0},
    '{16'd36530, 1'b0, 1'b0},
    '{16'd40001, 1'b1, 1'b0},
    '{16'd33999, 1'b1, 1'b1},
    '{16'd44001, 1'b1, 1'b1},
    '{16'd43500, 1'b0, 1'b1},
    '{16'd43500, 1'b1, 1'b0},
    '{16'd43000, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, bandSel = 1'b0, load = 1'b0;
  logic [15:0] chanWord = '0;
  logic [8:0]  divOut;
  logic        divValid, outOfRange;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  int m0, m1, m2, mc2p, mc3p, mc3pp;

  always #5 clk = ~clk;

  fracnChanDecoder #(.LB_MAX_WORD(43000)) i_fracnChanDecoder (
    .clk(clk), .rstN(rstN), .enable(enable), .bandSel(bandSel), .load(load),
    .chanWord(chanWord), .divOut(divOut), .divValid(divValid),
    .outOfRange(outOfRange)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    m0 = 0; m1 = 0; m2 = 0; mc2p = 0; mc3p = 0; mc3pp = 0;
  endtask

  task automatic modelStep(input int ip, input int f, output int val);
    int s, c1, c2, c3;
    s = m0 + f;  c1 = (s >= 260) ? 1 : 0; m0 = s - 260*c1;
    s = m1 + m0; c2 = (s >= 260) ? 1 : 0; m1 = s - 260*c2;
    s = m2 + m1; c3 = (s >= 260) ? 1 : 0; m2 = s - 260*c3;
    val = ip + c1 + c2 - mc2p + c3 - 2*mc3p + mc3pp;
    mc2p = c2; mc3pp = mc3p; mc3p = c3;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish();
  end

  initial begin
    int held, ip, f, exp, sum, drift;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(divOut == 0, "R1", "divOut in reset", divOut, 0);
    chk(divValid == 0, "R1", "divValid in reset", divValid, 0);
    chk(outOfRange == 0, "R1", "outOfRange in reset", outOfRange, 0);
    rstN = 1'b1;
    enable = 1'b1;
    repeat (4) @(negedge clk);
    // R10 no word loaded yet
    chk(divValid == 0, "R10", "valid before any load", divValid, 0);

    for (int v = 0; v < NV; v++) begin
      held = divOut;
      chanWord = VECS[v].word;
      bandSel = VECS[v].band;
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      chk(outOfRange == VECS[v].expOor, "R7", "range flag", outOfRange, VECS[v].expOor);
      chk(divValid == 0, "R6", "valid after load edge", divValid, 0);
      if (!VECS[v].expOor) begin
        ip = VECS[v].word / 260;
        f  = VECS[v].word % 260;
        modelClear();
        sum = 0;
        for (int n = 1; n <= 300; n++) begin
          @(negedge clk);
          modelStep(ip, f, exp);
          chk(divValid == 1, "R6", "valid while running", divValid, 1);
          chk(divOut == exp, "R3", "divide value", divOut, exp);
          chk((int'(divOut) >= ip - 3) && (int'(divOut) <= ip + 4),
              "R4", "value window", divOut, ip);
          if (f == 0) chk(divOut == ip, "R2", "integer-only word", divOut, ip);
          if (n <= 260) sum += int'(divOut);
          if (n == 260) begin
            drift = 260*(sum - 260*ip) - 260*f;
            chk(drift <= 780 && drift >= -780, "R5", "mean drift", drift, 0);
          end
        end
      end else begin
        for (int n = 0; n < 20; n++) begin
          @(negedge clk);
          chk(divOut == held, "R8", "held value", divOut, held);
          chk(divValid == 0, "R8", "valid while rejected", divValid, 0);
          chk(outOfRange == 1, "R8", "flag stays set", outOfRange, 1);
        end
      end
    end

    // R9 enable drop and restart (last word 43000, low band)
    held = divOut;
    enable = 1'b0;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      chk(divValid == 0, "R9", "valid while disabled", divValid, 0);
      chk(divOut == held, "R9", "held while disabled", divOut, held);
    end
    enable = 1'b1;
    modelClear();
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      modelStep(43000 / 260, 43000 % 260, exp);
      chk(divValid == 1, "R9", "valid after re-enable", divValid, 1);
      chk(divOut == exp, "R9", "restart sequence", divOut, exp);
    end

    // R8 rejected load after running, then recovery
    held = divOut;
    chanWord = 16'd50000; bandSel = 1'b1; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(outOfRange == 1, "R8", "flag on high word", outOfRange, 1);
    chk(divOut == held, "R8", "hold at reject", divOut, held);
    chanWord = 16'd39000; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(outOfRange == 0, "R7", "flag cleared by good load", outOfRange, 0);
    @(negedge clk);
    chk(divOut == 150, "R2", "39000 gives 150", divOut, 150);
    chk(divValid == 1, "R6", "valid one cycle later", divValid, 1);

    finish();
  end
endmodule